// File: doc/BRIEF.md
# Synchronous Burst Read Address Sequencer

This block is the memory-side controller for synchronous burst reads in a parallel flash-style device. A burst opens while chip-enable is low. The start address is taken by whichever happens first: an active clock edge that sees the active-low address strobe low, or the strobe's own rising edge. After a programmable initial latency the sequencer walks a 20-bit internal array address. Each active edge that samples the active-low advance input low steps the address by one. An edge that samples advance high freezes the address for a programmable number of ignored edges.

A configuration input chooses whether the rising or the falling clock edge is the active edge. A second configuration input chooses whether the ready output tracks the current cycle or leads it by one cycle. Ready has a separate drive-enable output that stands in for the high-impedance state while no burst is open. The block also decodes a write-protect lock map over 8 parameter blocks and 31 main blocks, placed for either a bottom-boot or a top-boot layout.

Top module: `burst_rd_seq`

## Requirements
- R1: With edge_fall_i at 0 all synchronous sampling happens on the rising clock edge; with edge_fall_i at 1 it happens on the falling edge, and rising edges have no effect.
- R2: While idle with ce_ni low, a burst opens at the first active edge where lat_ni is low, taking addr_i as it is at that edge. If lat_ni rose since the previous active edge, the burst opens instead with the address held at that rising edge. A strobe rise during an open burst is ignored.
- R3: The initial latency X is xlat_i, with values 0 and 1 treated as 2. adv_ni is first sampled on the X-th active edge after the opening edge, and the address does not change before then.
- R4: An active edge that samples adv_ni low while streaming increments arr_addr_o by one, modulo 2^20.
- R5: An active edge that samples adv_ni high while streaming holds arr_addr_o. The next Y active edges ignore adv_ni, where Y = ylat_i + 1.
- R6: With rdy_early_i at 0, rdy_o is high while the sequencer is streaming. With rdy_early_i at 1, rdy_o is high when the next state is streaming, one cycle sooner, and drops as soon as a hold is pending.
- R7: An active edge that samples ce_ni high returns the sequencer to idle, with rdy_en_o low after that edge.
- R8: While idle, rdy_o, rdy_en_o and dout_en_o are all low. Outside idle rdy_en_o is high. dout_en_o is high only after the initial latency, and only while oe_ni and ce_ni are low.
- R9: With wp_ni high lock_o is all zero. With wp_ni low every main block is locked, plus two parameter blocks. When top_boot_i is 0 the parameter blocks are lock_o[7:0], the main blocks are lock_o[38:8], and bits 0 and 1 are the locked pair. When top_boot_i is 1 the main blocks are lock_o[30:0], the parameter blocks are lock_o[38:31], and bits 37 and 38 are the locked pair.
- R10: ylat_i and rdy_early_i are taken only while idle. xlat_i is taken at the opening edge. Changes during a burst have no effect until the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Burst clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| edge_fall_i | input | 1 | 1 selects the falling edge as the active edge |
| ce_ni | input | 1 | Chip enable, active low; high aborts a burst |
| oe_ni | input | 1 | Output enable, active low |
| lat_ni | input | 1 | Address strobe, active low |
| adv_ni | input | 1 | Burst advance, active low |
| addr_i | input | 20 | Start address |
| xlat_i | input | 3 | Initial latency field |
| ylat_i | input | 2 | Hold latency field (Y = value + 1) |
| rdy_early_i | input | 1 | 1 makes ready lead by one cycle |
| top_boot_i | input | 1 | 1 places parameter blocks at the top |
| wp_ni | input | 1 | Write protect, active low |
| arr_addr_o | output | 20 | Internal array address |
| dout_en_o | output | 1 | Data output valid / drive enable |
| rdy_o | output | 1 | Ready, active high |
| rdy_en_o | output | 1 | Drive enable of ready |
| lock_o | output | 39 | Per-block lock map |

## Verification
The assertions assume that edge_fall_i changes only while no burst is open. They also assume that addr_i and lat_ni settle well away from active edges, since the strobe capture runs in its own clock domain, and that latency fields sampled at an edge are stable there. The bench drives every input a quarter period after an active edge. It toggles edge polarity only while idle, at a clock level that creates no extra active edge. It raises the strobe between edges only where the ordering of strobe and clock is the point of the test.

// File: rtl/burst_rd_pkg.sv
package burst_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XLAT = 2'd1,
    ST_STRM = 2'd2,
    ST_WAIT = 2'd3
  } seq_st_e;

  localparam int unsigned XLAT_MIN = 2;
endpackage

// File: rtl/brs_addr_capture.sv
// Captures the address on the strobe rising edge; a toggle flags the event
module brs_addr_capture #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              lat_ni,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] le_addr_o,
  output logic              le_tog_o
);
  always_ff @(posedge lat_ni or negedge rst_ni) begin
    if (!rst_ni) begin
      le_addr_o <= '0;
      le_tog_o  <= 1'b0;
    end else begin
      le_addr_o <= addr_i;
      le_tog_o  <= ~le_tog_o;
    end
  end
endmodule

// File: rtl/brs_ctrl.sv
module brs_ctrl
  import burst_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned XLAT_W = 3,
  parameter int unsigned YLAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              lat_ni,
  input  logic              adv_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] le_addr_i,
  input  logic              le_tog_i,
  input  logic [XLAT_W-1:0] xlat_i,
  input  logic [YLAT_W-1:0] ylat_i,
  input  logic              rdy_early_i,
  output logic [ADDR_W-1:0] arr_addr_o,
  output seq_st_e           st_o,
  output logic              rdy_o
);
  localparam int unsigned CNT_W = (XLAT_W > YLAT_W + 1) ? XLAT_W : YLAT_W + 1;

  seq_st_e           st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [YLAT_W-1:0] y_q;
  logic              early_q;
  logic              ack_q;
  logic              le_pend;
  logic [XLAT_W-1:0] x_ld;

  assign le_pend = le_tog_i ^ ack_q;
  assign x_ld    = (xlat_i < XLAT_W'(XLAT_MIN)) ? XLAT_W'(XLAT_MIN) : xlat_i;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    if (ce_ni) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          // a strobe rise since the last edge came first
          if (le_pend) begin
            st_d   = ST_XLAT;
            addr_d = le_addr_i;
            cnt_d  = CNT_W'(x_ld) - CNT_W'(1);
          end else if (!lat_ni) begin
            st_d   = ST_XLAT;
            addr_d = addr_i;
            cnt_d  = CNT_W'(x_ld) - CNT_W'(1);
          end
        end
        ST_XLAT: begin
          if (cnt_q == CNT_W'(1)) st_d = ST_STRM;
          else                    cnt_d = cnt_q - CNT_W'(1);
        end
        ST_STRM: begin
          if (!adv_ni) begin
            addr_d = addr_q + ADDR_W'(1);
          end else begin
            st_d  = ST_WAIT;
            cnt_d = CNT_W'(y_q) + CNT_W'(1);
          end
        end
        ST_WAIT: begin
          if (cnt_q == CNT_W'(1)) st_d = ST_STRM;
          else                    cnt_d = cnt_q - CNT_W'(1);
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      y_q     <= '0;
      early_q <= 1'b0;
      ack_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      ack_q  <= le_tog_i;
      if (st_q == ST_IDLE) begin
        y_q     <= ylat_i;
        early_q <= rdy_early_i;
      end
    end
  end

  assign arr_addr_o = addr_q;
  assign st_o       = st_q;
  assign rdy_o      = (st_q != ST_IDLE) &&
                      (early_q ? (st_d == ST_STRM) : (st_q == ST_STRM));
endmodule

// File: rtl/brs_lock_map.sv
module brs_lock_map #(
  parameter int unsigned N_PARAM = 8,
  parameter int unsigned N_MAIN  = 31,
  parameter int unsigned N_PROT  = 2
) (
  input  logic                        wp_ni,
  input  logic                        top_boot_i,
  output logic [N_PARAM+N_MAIN-1:0]   lock_o
);
  localparam int unsigned N_BLK = N_PARAM + N_MAIN;

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    localparam bit MAIN_BOT = (b >= N_PARAM);
    localparam bit MAIN_TOP = (b < N_MAIN);
    localparam bit PROT_BOT = (b < N_PROT);
    localparam bit PROT_TOP = (b >= N_BLK - N_PROT);
    assign lock_o[b] = !wp_ni && (top_boot_i ? (MAIN_TOP || PROT_TOP)
                                             : (MAIN_BOT || PROT_BOT));
  end
endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import burst_rd_pkg::*;
#(
  parameter int unsigned ADDR_W  = 20,
  parameter int unsigned XLAT_W  = 3,
  parameter int unsigned YLAT_W  = 2,
  parameter int unsigned N_PARAM = 8,
  parameter int unsigned N_MAIN  = 31,
  parameter int unsigned N_PROT  = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      edge_fall_i,
  input  logic                      ce_ni,
  input  logic                      oe_ni,
  input  logic                      lat_ni,
  input  logic                      adv_ni,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [XLAT_W-1:0]         xlat_i,
  input  logic [YLAT_W-1:0]         ylat_i,
  input  logic                      rdy_early_i,
  input  logic                      top_boot_i,
  input  logic                      wp_ni,
  output logic [ADDR_W-1:0]         arr_addr_o,
  output logic                      dout_en_o,
  output logic                      rdy_o,
  output logic                      rdy_en_o,
  output logic [N_PARAM+N_MAIN-1:0] lock_o
);
  logic              act_clk;
  logic [ADDR_W-1:0] le_addr;
  logic              le_tog;
  seq_st_e           seq_st;

  // edge select is static configuration; inversion makes the falling edge active
  assign act_clk = clk_i ^ edge_fall_i;

  brs_addr_capture #(.ADDR_W(ADDR_W)) i_cap (
    .lat_ni    (lat_ni),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .le_addr_o (le_addr),
    .le_tog_o  (le_tog)
  );

  brs_ctrl #(.ADDR_W(ADDR_W), .XLAT_W(XLAT_W), .YLAT_W(YLAT_W)) i_ctrl (
    .clk_i       (act_clk),
    .rst_ni      (rst_ni),
    .ce_ni       (ce_ni),
    .lat_ni      (lat_ni),
    .adv_ni      (adv_ni),
    .addr_i      (addr_i),
    .le_addr_i   (le_addr),
    .le_tog_i    (le_tog),
    .xlat_i      (xlat_i),
    .ylat_i      (ylat_i),
    .rdy_early_i (rdy_early_i),
    .arr_addr_o  (arr_addr_o),
    .st_o        (seq_st),
    .rdy_o       (rdy_o)
  );

  brs_lock_map #(.N_PARAM(N_PARAM), .N_MAIN(N_MAIN), .N_PROT(N_PROT)) i_lock (
    .wp_ni      (wp_ni),
    .top_boot_i (top_boot_i),
    .lock_o     (lock_o)
  );

  assign rdy_en_o  = (seq_st != ST_IDLE);
  assign dout_en_o = ((seq_st == ST_STRM) || (seq_st == ST_WAIT)) && !oe_ni && !ce_ni;
endmodule

// File: rtl/burst_rd_seq_chk.sv
module burst_rd_seq_chk
  import burst_rd_pkg::*;
#(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned N_BLK  = 39,
  parameter int unsigned N_LOCK = 33
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ce_ni,
  input logic              adv_ni,
  input logic              wp_ni,
  input seq_st_e           st,
  input logic [ADDR_W-1:0] arr_addr_o,
  input logic              rdy_o,
  input logic              rdy_en_o,
  input logic              dout_en_o,
  input logic [N_BLK-1:0]  lock_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> (!rdy_o && !rdy_en_o && !dout_en_o)); // R8

  AST_CE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ce_ni |=> (st == ST_IDLE && !rdy_en_o)); // R7

  AST_XLAT_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_XLAT && !ce_ni) |=> $stable(arr_addr_o)); // R3

  AST_ADV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_STRM && !adv_ni && !ce_ni) |=>
      (arr_addr_o == $past(arr_addr_o) + ADDR_W'(1))); // R4

  AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_WAIT && !ce_ni) |=> $stable(arr_addr_o)); // R5

  AST_LOCK_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_ni |-> (lock_o == '0)); // R9

  AST_LOCK_COUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wp_ni |-> ($countones(lock_o) == N_LOCK)); // R9
endmodule

bind burst_rd_seq burst_rd_seq_chk #(
  .ADDR_W (ADDR_W),
  .N_BLK  (N_PARAM + N_MAIN),
  .N_LOCK (N_MAIN + N_PROT)
) i_chk (
  .clk_i      (act_clk),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .adv_ni     (adv_ni),
  .wp_ni      (wp_ni),
  .st         (seq_st),
  .arr_addr_o (arr_addr_o),
  .rdy_o      (rdy_o),
  .rdy_en_o   (rdy_en_o),
  .dout_en_o  (dout_en_o),
  .lock_o     (lock_o)
);

// File: tb/test_burst_rd_seq.sv
`timescale 1ns/1ps
module test_burst_rd_seq;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        edge_fall_i = 1'b0;
  logic        ce_ni = 1'b1;
  logic        oe_ni = 1'b0;
  logic        lat_ni = 1'b1;
  logic        adv_ni = 1'b0;
  logic [19:0] addr_i = '0;
  logic [2:0]  xlat_i = 3'd2;
  logic [1:0]  ylat_i = 2'd0;
  logic        rdy_early_i = 1'b0;
  logic        top_boot_i = 1'b0;
  logic        wp_ni = 1'b1;
  logic [19:0] arr_addr_o;
  logic        dout_en_o, rdy_o, rdy_en_o;
  logic [38:0] lock_o;

  int checks = 0;
  int errors = 0;
  bit fall_mode = 1'b0;

  always #10 clk_i = ~clk_i; // 50 MHz

  burst_rd_seq i_burst_rd_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_fall_i(edge_fall_i), .ce_ni(ce_ni),
    .oe_ni(oe_ni), .lat_ni(lat_ni), .adv_ni(adv_ni), .addr_i(addr_i),
    .xlat_i(xlat_i), .ylat_i(ylat_i), .rdy_early_i(rdy_early_i),
    .top_boot_i(top_boot_i), .wp_ni(wp_ni), .arr_addr_o(arr_addr_o),
    .dout_en_o(dout_en_o), .rdy_o(rdy_o), .rdy_en_o(rdy_en_o), .lock_o(lock_o)
  );

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic act_edge();
    if (fall_mode) @(negedge clk_i);
    else           @(posedge clk_i);
    #5;
  endtask

  task automatic open_burst(input logic [19:0] a);
    ce_ni = 1'b0; lat_ni = 1'b0; addr_i = a;
    act_edge();
    addr_i = ~a;
    lat_ni = 1'b1;
  endtask

  task automatic close_burst();
    ce_ni = 1'b1;
    act_edge();
    chk("R7 abort rdy_en", rdy_en_o, 0);
    chk("R7 abort dout_en", dout_en_o, 0);
  endtask

  task automatic t_reset();
    chk("R8 reset rdy_en", rdy_en_o, 0);
    chk("R8 reset rdy", rdy_o, 0);
    chk("R8 reset dout_en", dout_en_o, 0);
    chk("R8 reset addr", arr_addr_o, 0);
  endtask

  task automatic t_basic();
    logic [19:0] a = 20'h01230;
    xlat_i = 3'd3; ylat_i = 2'd0; rdy_early_i = 1'b0; adv_ni = 1'b0; oe_ni = 1'b0;
    open_burst(a);
    chk("R2 edge capture", arr_addr_o, a);
    chk("R8 rdy_en open", rdy_en_o, 1);
    chk("R3 rdy in latency", rdy_o, 0);
    chk("R8 dout_en in latency", dout_en_o, 0);
    act_edge();
    chk("R3 adv ignored e1", arr_addr_o, a);
    chk("R2 strobe rise in burst ignored", arr_addr_o, a);
    act_edge();
    chk("R3 adv ignored e2", arr_addr_o, a);
    chk("R6 late ready", rdy_o, 1);
    chk("R8 dout_en streaming", dout_en_o, 1);
    ylat_i = 2'd3; rdy_early_i = 1'b1;
    act_edge();
    chk("R3 first sample", arr_addr_o, a + 1);
    chk("R10 early ignored mid burst", rdy_o, 1);
    act_edge();
    chk("R4 step", arr_addr_o, a + 2);
    adv_ni = 1'b1;
    act_edge();
    chk("R5 hold addr", arr_addr_o, a + 2);
    chk("R6 late ready low in hold", rdy_o, 0);
    adv_ni = 1'b0;
    act_edge();
    chk("R10 old Y ignored edge", arr_addr_o, a + 2);
    chk("R6 ready back", rdy_o, 1);
    act_edge();
    chk("R10 old Y resumes", arr_addr_o, a + 3);
    oe_ni = 1'b1; #1;
    chk("R8 oe gates dout_en", dout_en_o, 0);
    oe_ni = 1'b0; #1;
    close_burst();
  endtask

  task automatic t_ywait();
    logic [19:0] a = 20'h00500;
    xlat_i = 3'd0; ylat_i = 2'd3; rdy_early_i = 1'b0; adv_ni = 1'b0;
    open_burst(a);
    act_edge();
    chk("R3 clamp not yet", arr_addr_o, a);
    act_edge();
    chk("R3 clamp to 2", arr_addr_o, a + 1);
    adv_ni = 1'b1;
    act_edge();
    chk("R5 hold", arr_addr_o, a + 1);
    adv_ni = 1'b0;
    for (int i = 0; i < 3; i++) begin
      act_edge();
      chk("R5 y ignored", arr_addr_o, a + 1);
      chk("R6 late low in wait", rdy_o, 0);
    end
    act_edge();
    chk("R5 y last ignored", arr_addr_o, a + 1);
    act_edge();
    chk("R5 resume after y", arr_addr_o, a + 2);
    close_burst();
  endtask

  task automatic t_early();
    logic [19:0] a = 20'h0A000;
    xlat_i = 3'd2; ylat_i = 2'd0; rdy_early_i = 1'b1; adv_ni = 1'b0;
    open_burst(a);
    chk("R6 early ready leads", rdy_o, 1);
    act_edge();
    chk("R6 early ready stream", rdy_o, 1);
    adv_ni = 1'b1; #1;
    chk("R6 early drop on hold", rdy_o, 0);
    act_edge();
    chk("R5 hold first sample", arr_addr_o, a);
    chk("R6 early lead out of wait", rdy_o, 1);
    adv_ni = 1'b0;
    close_burst();
    rdy_early_i = 1'b0;
  endtask

  task automatic t_wrap();
    xlat_i = 3'd2; adv_ni = 1'b0;
    open_burst(20'hFFFFF);
    act_edge();
    act_edge();
    chk("R4 wrap", arr_addr_o, 20'h00000);
    close_burst();
  endtask

  task automatic t_strobe_first();
    logic [19:0] a = 20'h3C3C3;
    xlat_i = 3'd2;
    ce_ni = 1'b0; lat_ni = 1'b0; addr_i = a;
    #2 lat_ni = 1'b1;
    #2 addr_i = 20'h11111;
    act_edge();
    chk("R2 strobe rise first", arr_addr_o, a);
    chk("R2 burst open", rdy_en_o, 1);
    close_burst();
  endtask

  task automatic t_fall_edge();
    logic [19:0] a = 20'h77001;
    ce_ni = 1'b1;
    edge_fall_i = 1'b1; fall_mode = 1'b1; // clk high now: no spurious edge
    @(negedge clk_i); #5;
    ce_ni = 1'b0; lat_ni = 1'b0; addr_i = a;
    @(posedge clk_i); #5;
    chk("R1 rising edge inert", rdy_en_o, 0);
    @(negedge clk_i); #5;
    chk("R1 falling edge opens", rdy_en_o, 1);
    chk("R1 falling edge addr", arr_addr_o, a);
    lat_ni = 1'b1;
    close_burst();
    edge_fall_i = 1'b0; fall_mode = 1'b0; // clk low now: no spurious edge
  endtask

  task automatic t_lock();
    logic [38:0] exp;
    for (int m = 0; m < 4; m++) begin
      wp_ni = m[0]; top_boot_i = m[1];
      #1;
      exp = '0;
      if (!wp_ni) begin
        for (int b = 0; b < 39; b++) begin
          if (top_boot_i) exp[b] = (b < 31) || (b >= 37);
          else            exp[b] = (b >= 8) || (b < 2);
        end
      end
      chk("R9 lock map", lock_o, exp);
    end
    wp_ni = 1'b1; top_boot_i = 1'b0;
  endtask

  initial begin
    #45 rst_ni = 1'b1;
    @(posedge clk_i); #5;
    t_reset();
    t_basic();
    t_ywait();
    t_early();
    t_wrap();
    t_strobe_first();
    t_fall_edge();
    act_edge();
    t_lock();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule